// File: doc/BRIEF.md
# Fixed-Sequence Parallel Bus Read Master

This block is the processor side of a simple parallel bus and runs one read cycle at a time. An internal user hands it a word address and a set of byte-lane selects. The block then steps through eight half-states, S0 to S7, each one clock of its double-rate clock. The sequence floats the address pads, drives the new address, lowers the address strobe and the selected lane strobes, samples the data bus at one fixed edge, and returns the captured word with a one-clock done pulse.

The timing is fixed and the cycle cannot be stretched. Memory on the bus therefore has to present valid data a setup time before the edge that closes S6. Data that arrives later is not seen. The cycle leaves the strobes raised while the address is still held, so no address change can overlap an active strobe.

Top module: `bus_read_seq`

## Requirements
- R1: While reset is held, and right after it is released, the address pads are disabled (`bus_addr_oe`=0), all strobes are high, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken in a clock where `req_valid` and `req_ready` are both 1; that clock is S0. The following seven clocks are S1..S7, and `req_ready` returns to 1 in the clock after S7.
- R3: The address pads are disabled in S0 and enabled from S1 through S7. While they are enabled, `bus_addr` carries the address taken with the request. In the clock after S7 the pads are disabled again.
- R4: `bus_as_n` is low exactly in S2..S6. It is high in S0, S1 and S7, so it rises while the address is still driven.
- R5: `bus_ds_n[i]` is low exactly in S2..S6 when `req_sel[i]` was 1, and stays high otherwise. Bit 1 is the upper lane (data bits 15:8) and bit 0 is the lower lane (bits 7:0). With no lanes selected, no data strobe falls.
- R6: The data bus is sampled only at the clock edge that ends S6. A value present only in S7 or later does not reach the result, and neither does a value present only before S6.
- R7: `rsp_done` is 1 for exactly the one clock of S7. In that clock `rsp_data` holds the sampled word, with every unselected lane forced to zero.
- R8: Requests presented while a cycle is running (S1..S7) are ignored: the driven address, lane strobes and result are those of the request already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one period per half-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle in S0 and able to take a request |
| req_addr | input | ADDR_W | Word address of the read |
| req_sel | input | LANES | Byte-lane selects, bit 1 upper, bit 0 lower |
| rsp_done | output | 1 | One-clock completion pulse in S7 |
| rsp_data | output | DATA_W | Captured word, unselected lanes zero |
| bus_addr | output | ADDR_W | Address pad value, zero while floated |
| bus_addr_oe | output | 1 | Address pad output enable (0 = high impedance) |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | LANES | Per-lane data strobes, active low |
| bus_data | input | DATA_W | Data bus from memory |

## Verification
The bench builds the block with an 8-bit address and a 16-bit data bus, which gives two byte lanes. At that size every lane-select pattern can be combined with every data arrival half-state from S1 to S7 and with several address patterns. Arrival in S6 is the last one that is captured and arrival in S7 must be missed, so the whole boundary of the sampling window is covered. Some of the runs also present conflicting requests in mid-cycle to show that the address and the result are not disturbed.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [2:0] {
        PH_S0 = 3'd0,
        PH_S1 = 3'd1,
        PH_S2 = 3'd2,
        PH_S3 = 3'd3,
        PH_S4 = 3'd4,
        PH_S5 = 3'd5,
        PH_S6 = 3'd6,
        PH_S7 = 3'd7
    } phase_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/brs_phase_ctr.sv
module brs_phase_ctr
    import brs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase_q,
    output phase_e phase_d
);

    // Idle parks in S0; once started, the counter runs through S7 and wraps.
    always_comb begin
        phase_d = phase_q;
        if (phase_q != PH_S0 || start) begin
            phase_d = phase_e'(3'(phase_q + 3'd1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_S0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/brs_strobe_gen.sv
module brs_strobe_gen
    import brs_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  phase_e           phase,
    input  logic [LANES-1:0] sel,
    output logic             addr_oe,
    output logic             as_n,
    output logic [LANES-1:0] ds_n,
    output logic             done
);

    logic strobe_window;

    always_comb begin
        strobe_window = (phase inside {PH_S2, PH_S3, PH_S4, PH_S5, PH_S6});
        addr_oe       = (phase != PH_S0);
        as_n          = !strobe_window;
        done          = (phase == PH_S7);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_strb
        assign ds_n[g] = !(strobe_window && sel[g]);
    end

endmodule

// File: rtl/brs_lane_capture.sv
module brs_lane_capture
    import brs_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] bus_word,
    input  logic [LANES-1:0]  sel,
    output logic [DATA_W-1:0] masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
        assign masked[g*LANE_W +: LANE_W] =
            sel[g] ? bus_word[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/bus_read_seq.sv
module bus_read_seq
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_sel,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic              bus_as_n,
    output logic [LANES-1:0]  bus_ds_n,
    input  logic [DATA_W-1:0] bus_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  sel;
        logic [DATA_W-1:0] data;
        logic              oe;
        logic              as_n;
        logic [LANES-1:0]  ds_n;
        logic              done;
    } regs_t;

    regs_t             r_d, r_q;
    phase_e            ph_q, ph_d;
    logic              accept;
    logic              nx_oe, nx_as_n, nx_done;
    logic [LANES-1:0]  nx_ds_n;
    logic [DATA_W-1:0] lane_word;

    assign accept = req_valid && (ph_q == PH_S0);

    brs_phase_ctr u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .phase_q (ph_q),
        .phase_d (ph_d)
    );

    // Strobes are decoded from the next phase and then registered.
    brs_strobe_gen #(.LANES(LANES)) u_strb (
        .phase   (ph_d),
        .sel     (r_d.sel),
        .addr_oe (nx_oe),
        .as_n    (nx_as_n),
        .ds_n    (nx_ds_n),
        .done    (nx_done)
    );

    brs_lane_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .bus_word (bus_data),
        .sel      (r_q.sel),
        .masked   (lane_word)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.addr = req_addr;
            r_d.sel  = req_sel;
        end
        // The single sampling point is the edge that leaves S6.
        if (ph_q == PH_S6) begin
            r_d.data = lane_word;
        end
        r_d.oe   = nx_oe;
        r_d.as_n = nx_as_n;
        r_d.ds_n = nx_ds_n;
        r_d.done = nx_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.as_n <= 1'b1;
            r_q.ds_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (ph_q == PH_S0);
    assign rsp_done    = r_q.done;
    assign rsp_data    = r_q.data;
    assign bus_addr_oe = r_q.oe;
    assign bus_addr    = r_q.oe ? r_q.addr : '0;
    assign bus_as_n    = r_q.as_n;
    assign bus_ds_n    = r_q.ds_n;

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_oe,
    input logic              bus_as_n,
    input logic [LANES-1:0]  bus_ds_n
);

    // R2: idle means no address driven and no strobe active
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_addr_oe && bus_as_n));

    // R4: address strobe only while the address is driven
    a_r4_as_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> bus_addr_oe);

    // R4: strobe already raised when the result appears
    a_r4_as_high_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> bus_as_n);

    // R5: a lane strobe only inside the address strobe window
    a_r5_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds_n != '1) |-> !bus_as_n);

    // R7: done lasts one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R3: pads released right after the cycle ends
    a_r3_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !bus_addr_oe);

    // R8: driven address never changes mid-cycle
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_oe && $past(bus_addr_oe)) |-> $stable(bus_addr));

endmodule

bind bus_read_seq brs_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_brs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_addr    (bus_addr),
    .bus_addr_oe (bus_addr_oe),
    .bus_as_n    (bus_as_n),
    .bus_ds_n    (bus_ds_n)
);

// File: tb/tb_bus_read_seq.sv
module tb_bus_read_seq;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LN-1:0] req_sel = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_oe;
    logic          bus_as_n;
    logic [LN-1:0] bus_ds_n;
    logic [DW-1:0] bus_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_read_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_sel(req_sel),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
        .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
        .bus_data(bus_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One read; memory presents the true word from cycle index 1+lat through 7.
    task automatic run_read(input logic [AW-1:0] addr, input logic [LN-1:0] sel,
                            input int lat, input bit poke);
        logic [DW-1:0] word, junk, mask, exp_data;
        word = {addr ^ 8'hA5, ~addr} + 16'(lat * 16'h0101);
        junk = ~word;
        mask = {sel[1] ? 8'hFF : 8'h00, sel[0] ? 8'hFF : 8'h00};
        exp_data = ((lat <= 5) ? word : junk) & mask;
        @(negedge clk);
        req_addr  = addr;
        req_sel   = sel;
        req_valid = 1'b1;
        bus_data  = junk;
        check("R2", "ready at S0", 32'(req_ready), 32'd1);
        check("R3", "oe at S0", 32'(bus_addr_oe), 32'd0);
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            req_valid = poke && (k >= 2) && (k <= 5);
            req_addr  = poke ? ~addr : addr;
            req_sel   = poke ? ~sel : sel;
            bus_data  = (k >= 1 + lat && k <= 7) ? word : junk;
            check("R2", "ready", 32'(req_ready), 32'(k == 8));
            check("R3", "addr oe", 32'(bus_addr_oe), 32'(k >= 1 && k <= 7));
            if (k >= 1 && k <= 7)
                check(poke ? "R8" : "R3", "addr value", 32'(bus_addr), 32'(addr));
            check("R4", "as_n", 32'(bus_as_n), 32'(!(k >= 2 && k <= 6)));
            for (int i = 0; i < LN; i++)
                check(poke ? "R8" : "R5", "ds_n lane", 32'(bus_ds_n[i]),
                      32'(!(k >= 2 && k <= 6 && sel[i])));
            check("R7", "done", 32'(rsp_done), 32'(k == 7));
            if (k == 7)
                check((lat == 6 || lat == 5) ? "R6" : "R7", "rsp_data",
                      32'(rsp_data), 32'(exp_data));
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "oe in reset", 32'(bus_addr_oe), 32'd0);
        check("R1", "as_n in reset", 32'(bus_as_n), 32'd1);
        check("R1", "ds_n in reset", 32'(bus_ds_n), 32'h3);
        check("R1", "done in reset", 32'(rsp_done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "ready after reset", 32'(req_ready), 32'd1);
        check("R1", "oe after reset", 32'(bus_addr_oe), 32'd0);
        check("R1", "as_n after reset", 32'(bus_as_n), 32'd1);
        for (int s = 0; s < 4; s++)
            for (int l = 0; l <= 6; l++)
                for (int a = 0; a < 3; a++)
                    run_read(8'(a == 0 ? 8'h00 : a == 1 ? 8'hFF : 8'h3C + s * 16 + l),
                             2'(s), l, a == 2);
        // idle gap: nothing moves without a request
        repeat (3) @(negedge clk);
        check("R2", "idle done", 32'(rsp_done), 32'd0);
        check("R2", "idle oe", 32'(bus_addr_oe), 32'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule